// File: doc/BRIEF.md
# Write-Protected Presence-Detect EEPROM Target

This block is a two-wire (I2C) target that behaves like a 256-byte configuration memory. It sits on a board-level serial bus next to a memory module. A host reads identification bytes from it and may store its own data in the upper half. Both bus lines are oversampled by a fast system clock. SDA is driven through an open-drain style output enable: when `sda_oe_o` is high, the pad pulls the line low. SCL is input only.

The lower half of the memory is fixed at reset and can never be changed. The upper half accepts writes unless the protect input is high. In both cases the bus transaction completes normally and every byte is acknowledged.

A stop condition that closes a transaction carrying at least one data byte starts an internal program interval. For that whole interval the target ignores its own address. The interval length is a parameter counted in system-clock cycles.

Top module: `presence_eeprom`

## Requirements
- R1: The target acknowledges (pulls SDA low during the 9th SCL pulse) only an address byte whose upper seven bits, sent MSB first, equal `1010` followed by `strap_i[2:0]`. Bit 0 of that byte is the direction: 0 means write, 1 means read. Any other address gets no acknowledge, and the target stays silent until the next start.
- R2: A write transaction is a write address, then one word-address byte, then data bytes. Each data byte aimed at bytes 128..255 is stored while `wp_i` is low, and each one is acknowledged.
- R3: Data bytes aimed at bytes 0..127 are acknowledged, but the memory keeps its old contents.
- R4: While `wp_i` is high, data bytes aimed at bytes 128..255 are acknowledged, but the memory keeps its old contents.
- R5: A random read returns the byte at the given word address. It is a write address and a word-address byte, then a repeated start and a read address.
- R6: During a read, the target sends the byte at the pointer MSB first and then advances the pointer. Each host acknowledge continues with the next byte, and the pointer wraps from 255 to 0. A host non-acknowledge ends the sending.
- R7: The pointer also advances after every data byte of a write and wraps from 255 to 0, whether or not that byte was stored.
- R8: From the stop that ends a write carrying at least one data byte, the target does not acknowledge its address for `PROG_CYCLES` system clocks. After that it responds normally.
- R9: After reset, the contents are as follows:
  - byte i for i < 63 holds (37*i + 11) mod 256;
  - byte 63 holds the low 8 bits of the sum of bytes 0..62;
  - byte i for i >= 64 holds 255 - i.
- R10: `sda_oe_o` changes only while SCL is low.
- R11: After reset, `sda_oe_o` is low and the pointer is 0, so a read with no word address returns byte 0.
- R12: A write transaction that carries only a word address and no data byte starts no program interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wire |
| strap_i | input | 3 | Board straps forming the low three address bits |
| wp_i | input | 1 | High blocks writes to the upper half |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
Writes are aimed at three kinds of target: an open upper byte, a lower byte, and an upper byte with protection raised. Each write is read back, so a stored byte, a locked byte and a protected byte each show up in the data. Reads are tried in three forms: current-address reads right after reset, random reads at scattered addresses including the checksum byte, and sequential reads that cross the 255-to-0 wrap. These separate pointer loading from pointer advance. A wrapping multi-byte write that ends in the locked half tests the pointer and the lock together. An address attempt issued straight after a data write's stop, compared with one after a word-address-only transaction, tells the program interval apart from plain address decoding.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int ADDR_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int SUM_LAST = 62;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WORD, ST_WORD_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK, ST_RWAIT, ST_HOLD
  } link_st_e;

  // reset image: ramp below the checksum, checksum, then descending fill
  function automatic logic [7:0] seed_byte(input int unsigned idx);
    logic [7:0] acc;
    acc = 8'h00;
    if (idx <= SUM_LAST) return 8'((idx * 37 + 11) & 255);
    if (idx == SUM_LAST + 1) begin
      for (int unsigned k = 0; k <= SUM_LAST; k++) acc = acc + 8'((k * 37 + 11) & 255);
      return acc;
    end
    return 8'(255 - (idx & 255));
  endfunction
endpackage

// File: rtl/pe_line_sync.sv
module pe_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw, cur, prev_q;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '1;
      else         sh_q <= {sh_q[STAGES-2:0], raw[g]};
    end
    assign cur[g] = sh_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= cur;
  end

  assign sda_o      = cur[0];
  assign scl_rise_o = cur[1] & ~prev_q[1];
  assign scl_fall_o = ~cur[1] & prev_q[1];
  assign start_o    = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
  assign stop_o     = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
endmodule

// File: rtl/pe_prog_timer.sv
module pe_prog_timer #(
  parameter int CYCLES = 3750000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pe_byte_store.sv
module pe_byte_store
  import pe_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= seed_byte(i);
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pe_link_fsm.sv
module pe_link_fsm
  import pe_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [2:0]    strap_i,
  input  logic          wp_i,
  input  logic          busy_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] ptr_o,
  output logic          we_o,
  output logic [7:0]    wdata_o,
  output logic          prog_start_o,
  output logic          sda_oe_o
);
  link_st_e      st_q;
  logic [3:0]    cnt_q;
  logic [7:0]    rx_q, tx_q;
  logic [AW-1:0] ptr_q;
  logic          dirty_q;
  logic          byte_done, addr_hit;

  assign byte_done = scl_fall_i && (cnt_q == 4'd8);
  assign addr_hit  = (rx_q[7:1] == {DEV_TYPE, strap_i}) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      dirty_q <= 1'b0;
    end else if (stop_i) begin
      st_q    <= ST_IDLE;
      dirty_q <= 1'b0;
    end else if (start_i) begin
      st_q  <= ST_DEV;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_DEV, ST_WORD, ST_WDAT: begin
          if (scl_rise_i) begin
            rx_q  <= {rx_q[6:0], sda_s_i};
            cnt_q <= cnt_q + 4'd1;
          end else if (byte_done) begin
            cnt_q <= '0;
            if (st_q == ST_DEV) begin
              st_q <= addr_hit ? ST_DEV_ACK : ST_HOLD;
            end else if (st_q == ST_WORD) begin
              ptr_q <= rx_q[AW-1:0];
              st_q  <= ST_WORD_ACK;
            end else begin
              ptr_q   <= ptr_q + 1'b1;
              dirty_q <= 1'b1;
              st_q    <= ST_WDAT_ACK;
            end
          end
        end
        ST_DEV_ACK: if (scl_fall_i) begin
          if (rx_q[0]) begin
            tx_q  <= rd_data_i;
            ptr_q <= ptr_q + 1'b1;
            cnt_q <= '0;
            st_q  <= ST_RDAT;
          end else begin
            st_q <= ST_WORD;
          end
        end
        ST_WORD_ACK, ST_WDAT_ACK: if (scl_fall_i) st_q <= ST_WDAT;
        ST_RDAT: if (scl_fall_i) begin
          if (cnt_q == 4'd7) begin
            cnt_q <= '0;
            st_q  <= ST_RACK;
          end else begin
            tx_q  <= {tx_q[6:0], 1'b0};
            cnt_q <= cnt_q + 4'd1;
          end
        end
        ST_RACK: if (scl_rise_i) begin
          if (!sda_s_i) begin
            tx_q  <= rd_data_i;
            ptr_q <= ptr_q + 1'b1;
            st_q  <= ST_RWAIT;
          end else begin
            st_q <= ST_HOLD;
          end
        end
        ST_RWAIT: if (scl_fall_i) begin
          cnt_q <= '0;
          st_q  <= ST_RDAT;
        end
        default: ;
      endcase
    end
  end

  // only the upper half, and only with protect low, reaches the array
  assign we_o         = (st_q == ST_WDAT) && byte_done && !start_i && !stop_i
                        && ptr_q[AW-1] && !wp_i;
  assign wdata_o      = rx_q;
  assign ptr_o        = ptr_q;
  assign prog_start_o = stop_i && dirty_q;

  always_comb begin
    unique case (st_q)
      ST_DEV_ACK, ST_WORD_ACK, ST_WDAT_ACK: sda_oe_o = 1'b1;
      ST_RDAT:                              sda_oe_o = ~tx_q[7];
      default:                              sda_oe_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/presence_eeprom.sv
module presence_eeprom
  import pe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PROG_CYCLES = 3750000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              prog_busy, prog_start, mem_we;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        wdata, rdata;

  pe_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  pe_link_fsm #(.AW(ADDR_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sda_s_i      (sda_s),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .start_i      (start_evt),
    .stop_i       (stop_evt),
    .strap_i      (strap_i),
    .wp_i         (wp_i),
    .busy_i       (prog_busy),
    .rd_data_i    (rdata),
    .ptr_o        (ptr),
    .we_o         (mem_we),
    .wdata_o      (wdata),
    .prog_start_o (prog_start),
    .sda_oe_o     (sda_oe_o)
  );

  pe_byte_store #(.AW(ADDR_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (ptr),
    .wdata_i (wdata),
    .raddr_i (ptr),
    .rdata_o (rdata)
  );

  pe_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (prog_start),
    .busy_o  (prog_busy)
  );
endmodule

// File: rtl/pe_checker.sv
module pe_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_oe_i,
  input logic       scl_s_i,
  input logic       busy_i,
  input logic       stop_i,
  input logic       wp_i,
  input logic       we_i,
  input logic [7:0] lock_byte_i,
  input logic [7:0] top_byte_i
);
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_i); // R8
  AST_BUSY_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(stop_i)); // R8
  AST_LOCK_BYTE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(lock_byte_i)); // R3
  AST_WP_FREEZES_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wp_i) |-> $stable(top_byte_i)); // R4
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_s_i); // R10
  AST_WRITE_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> sda_oe_i); // R2
endmodule

bind presence_eeprom pe_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sda_oe_i    (sda_oe_o),
  .scl_s_i     (u_sync.cur[1]),
  .busy_i      (prog_busy),
  .stop_i      (stop_evt),
  .wp_i        (wp_i),
  .we_i        (mem_we),
  .lock_byte_i (u_store.mem_q[63]),
  .top_byte_i  (u_store.mem_q[255])
);

// File: tb/presence_eeprom_tb.sv
module presence_eeprom_tb;
  localparam int PROG = 400;
  localparam int Q    = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};
  localparam logic [7:0] DEV_BAD = {4'b1010, 3'b011, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  wire  sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  presence_eeprom #(.PROG_CYCLES(PROG)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .strap_i  (STRAP),
    .wp_i     (wp),
    .sda_oe_o (sda_oe)
  );

  typedef struct {int val; string req;} item_t;
  item_t exp_q[$];
  item_t obs_q[$];
  int checks = 0, failures = 0, r10_bad = 0;
  logic [7:0] model [256];

  function automatic logic [7:0] ref_byte(input int i);
    int s;
    if (i < 63) return 8'((i * 37 + 11) % 256);
    if (i == 63) begin
      s = 0;
      for (int k = 0; k < 63; k++) s += (k * 37 + 11) % 256;
      return 8'(s % 256);
    end
    return 8'(255 - i);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qwait();
    m_scl = 1'b1; qwait();
    m_sda = 1'b0; qwait();
    m_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qwait();
    m_scl = 1'b1; qwait();
    m_sda = 1'b1; qwait(); qwait();
  endtask

  task automatic wbit(input logic b);
    m_sda = b; qwait();
    m_scl = 1'b1; qwait(); qwait();
    m_scl = 1'b0; qwait();
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; qwait();
    m_scl = 1'b1; qwait();
    b = sda_line; qwait();
    m_scl = 1'b0; qwait();
  endtask

  // driver side: expected ack pushed, observed ack handed to the monitor
  task automatic put_byte(input logic [7:0] v, input bit exp_ack, input string req);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    exp_q.push_back('{int'(exp_ack), {req, " ack"}});
    obs_q.push_back('{int'(!b), {req, " ack"}});
  endtask

  task automatic get_byte(input logic [7:0] expv, input bit last, input string req);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(last);
    exp_q.push_back('{int'(expv), {req, " data"}});
    obs_q.push_back('{int'(v), {req, " data"}});
  endtask

  task automatic mem_write(input int addr, input logic [7:0] d[$], input string req);
    bus_start();
    put_byte(DEV_W, 1'b1, req);
    put_byte(8'(addr), 1'b1, req);
    foreach (d[i]) begin
      int a = (addr + i) % 256;
      put_byte(d[i], 1'b1, req);
      if (a >= 128 && !wp) model[a] = d[i];
    end
    bus_stop();
    repeat (PROG + 60) @(posedge clk);
    #1;
  endtask

  task automatic mem_read(input int addr, input int n, input string req);
    bus_start();
    put_byte(DEV_W, 1'b1, req);
    put_byte(8'(addr), 1'b1, req);
    bus_start();
    put_byte(DEV_R, 1'b1, req);
    for (int i = 0; i < n; i++) get_byte(model[(addr + i) % 256], i == n - 1, req);
    bus_stop();
  endtask

  // monitor: pairs expected with observed as results arrive
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && obs_q.size() > 0) begin
        item_t e, o;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        check(o.val == e.val, e.req, o.val, e.val);
      end
    end
  end

  // R10: output enable must only move while the bus clock is low
  initial begin
    logic oe_prev;
    oe_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && sda_oe !== oe_prev && m_scl) r10_bad++;
      oe_prev = sda_oe;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d[$];
    for (int i = 0; i < 256; i++) model[i] = ref_byte(i);
    repeat (5) @(posedge clk);
    #1;
    check(sda_oe == 1'b0, "R11 reset oe", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;

    // R11: current-address read starts at byte 0
    bus_start();
    put_byte(DEV_R, 1'b1, "R1");
    get_byte(model[0], 1'b1, "R11");
    bus_stop();

    // R1: strap mismatch gets no acknowledge
    bus_start();
    put_byte(DEV_BAD, 1'b0, "R1");
    bus_stop();

    mem_read(63, 1, "R9");
    mem_read(10, 2, "R9");
    mem_read(200, 1, "R5");

    d = '{8'hA5};
    mem_write(130, d, "R2");
    mem_read(130, 1, "R2");

    d = '{8'h5A};
    mem_write(20, d, "R3");
    mem_read(20, 1, "R3");

    wp = 1'b1;
    d = '{8'h3C};
    mem_write(140, d, "R4");
    wp = 1'b0;
    mem_read(140, 1, "R4");

    mem_read(254, 4, "R6");

    d = '{8'h11, 8'h22, 8'h33};
    mem_write(254, d, "R7");
    mem_read(254, 3, "R7");

    // R8: address ignored straight after a data write, answered later
    bus_start();
    put_byte(DEV_W, 1'b1, "R8");
    put_byte(8'd150, 1'b1, "R8");
    put_byte(8'h77, 1'b1, "R8");
    bus_stop();
    model[150] = 8'h77;
    bus_start();
    put_byte(DEV_W, 1'b0, "R8");
    bus_stop();
    repeat (PROG + 100) @(posedge clk);
    #1;
    mem_read(150, 1, "R8");

    // R12: word address only, then an immediate read is answered
    bus_start();
    put_byte(DEV_W, 1'b1, "R12");
    put_byte(8'd5, 1'b1, "R12");
    bus_stop();
    bus_start();
    put_byte(DEV_R, 1'b1, "R12");
    get_byte(model[5], 1'b1, "R12");
    bus_stop();

    repeat (20) @(posedge clk);
    #1;
    check(r10_bad == 0, "R10 oe moved with SCL high", r10_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule